// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block sits between a simple request source and a DDR4-style command bus. Each request names a bank group, a bank, a row and a column, and says whether it is a read or a write and whether the row should close once the access is done. The block keeps a table with one entry per bank. Each entry records whether a row is open in that bank and which row it is. From that table it picks one of three legal sequences.

- Hit: a request to the row that is already open gets a single column command.
- Closed bank: a request to a bank with no open row gets an activate, then the column command.
- Conflict: a request to a bank that has a different row open gets a precharge, then an activate, then the column command.

Fixed minimum gaps, set by parameters, separate a precharge from the following activate and an activate from the following column command. While a precharge or an activate sequence is in progress, the request port holds off new requests. A column command can carry an auto-precharge flag. After such a command the block records the bank as closed, so the next access to that bank starts with an activate and needs no precharge.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset the block drives the idle command and raises req_ready. Every bank counts as closed. The idle command is cmd_cs_n=1, cmd_act_n=1, cmd_code=3'b111, and cmd_bg, cmd_ba, cmd_addr and cmd_ap all zero.
- R2: A request accepted on clock edge A that targets a closed bank produces an activate in the cycle after A. The activate has cmd_cs_n=0, cmd_act_n=0, cmd_code=3'b000, the request's bank group and bank, and the row zero-extended on cmd_addr. The column command follows T_RCD cycles after the activate, and the idle command is driven in the cycles between them.
- R3: A request that targets the open row of its bank produces the column command in the cycle after acceptance, with no activate. req_ready stays high.
- R4: A request that targets a bank with a different row open produces a precharge in the cycle after acceptance. The precharge has cmd_cs_n=0, cmd_act_n=1, cmd_code=3'b010, the target bank group and bank, and cmd_addr=0. The activate follows T_RP cycles later, and the column command follows T_RCD cycles after the activate.
- R5: A column command carries the request's auto-precharge flag on cmd_ap. After a column command with cmd_ap=1 the bank is closed, so the next access to the same row starts with an activate and no precharge. cmd_ap is never high on any other command.
- R6: A column command drives cmd_cs_n=0 and cmd_act_n=1. Its cmd_code is 3'b101 for a read and 3'b100 for a write. The column sits zero-extended on cmd_addr. Every cycle that carries no command drives the idle command.
- R7: req_ready is low from the cycle after a miss or conflict is accepted until the cycle in which its column command appears; req_ready is high in that cycle. A request held on the port during the stall is accepted only when req_ready is high again.
- R8: Banks are tracked independently. The bank index is {bank group, bank}. An activate is only ever sent to a closed bank, and a precharge or column command only to an open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_bg | input | BG_W | Bank group |
| req_ba | input | BA_W | Bank within group |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd_cs_n | output | 1 | Chip select, low on every issued command |
| cmd_act_n | output | 1 | Low marks an activate |
| cmd_code | output | 3 | Command code |
| cmd_bg | output | BG_W | Command bank group |
| cmd_ba | output | BA_W | Command bank |
| cmd_addr | output | max(ROW_W,COL_W) | Row on activate, column on column command |
| cmd_ap | output | 1 | Auto-precharge flag on column commands |

## Verification
All command outputs are registered, so the first command of a sequence is due in the cycle after the accepting edge. For a conflict, the activate is due T_RP cycles after the precharge, and the column command is due T_RCD cycles after the activate. req_ready is expected low up to the column cycle and high in it. After each accepting edge the bench samples every falling edge up to the column command. At each sample it compares the whole command word with the value its own per-bank model predicts for that offset, with the idle command between commands. A held second request checks that nothing from it appears before its acceptance in the column cycle of the first request.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    CODE_ACT = 3'b000,
    CODE_PRE = 3'b010,
    CODE_WR  = 3'b100,
    CODE_RD  = 3'b101,
    CODE_NOP = 3'b111
  } cmd_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RP   = 2'd1,
    ST_RCD  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/brt_gap_timer.sv
module brt_gap_timer #(
  parameter int GAP = 2,
  localparam int CNT_W = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= CNT_W'(GAP - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/brt_row_table.sv
module brt_row_table #(
  parameter int IDX_W = 4,
  parameter int ROW_W = 18,
  localparam int NB = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] set_row,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_open,
  output logic [ROW_W-1:0] rd_row
);
  logic             open_all [NB];
  logic [ROW_W-1:0] row_all  [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (set_en && wr_idx == IDX_W'(i)) begin
        open_r <= 1'b1;
        row_r  <= set_row;
      end else if (clr_en && wr_idx == IDX_W'(i)) begin
        open_r <= 1'b0;
      end
    end
    assign open_all[i] = open_r;
    assign row_all[i]  = row_r;
  end

  assign rd_open = open_all[rd_idx];
  assign rd_row  = row_all[rd_idx];
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 18,
  parameter int COL_W = 10,
  parameter int T_RP  = 2,
  parameter int T_RCD = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BG_W-1:0]   req_bg,
  input  logic [BA_W-1:0]   req_ba,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_cs_n,
  output logic              cmd_act_n,
  output logic [2:0]        cmd_code,
  output logic [BG_W-1:0]   cmd_bg,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap
);
  localparam int IDX_W = BG_W + BA_W;

  function automatic logic [IDX_W-1:0] bank_idx(logic [BG_W-1:0] g, logic [BA_W-1:0] a);
    return {g, a};
  endfunction

  function automatic logic [ADDR_W-1:0] widen_row(logic [ROW_W-1:0] r);
    return ADDR_W'(r);
  endfunction

  function automatic logic [ADDR_W-1:0] widen_col(logic [COL_W-1:0] c);
    return ADDR_W'(c);
  endfunction

  trk_state_e state_q;

  logic             q_write, q_ap;
  logic [BG_W-1:0]  q_bg;
  logic [BA_W-1:0]  q_ba;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;

  // current request: live inputs while idle, held copy otherwise
  logic             in_idle;
  logic             cur_write, cur_ap;
  logic [BG_W-1:0]  cur_bg;
  logic [BA_W-1:0]  cur_ba;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [IDX_W-1:0] cur_idx;

  assign in_idle   = (state_q == ST_IDLE);
  assign cur_write = in_idle ? req_write   : q_write;
  assign cur_ap    = in_idle ? req_autopre : q_ap;
  assign cur_bg    = in_idle ? req_bg      : q_bg;
  assign cur_ba    = in_idle ? req_ba      : q_ba;
  assign cur_row   = in_idle ? req_row     : q_row;
  assign cur_col   = in_idle ? req_col     : q_col;
  assign cur_idx   = bank_idx(cur_bg, cur_ba);

  // named internal events
  logic             lk_open, lk_hit, rp_done, rcd_done;
  logic             ev_take, ev_pre, ev_act, ev_col;
  logic [ROW_W-1:0] lk_row;

  brt_row_table #(.IDX_W(IDX_W), .ROW_W(ROW_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ev_act),
    .clr_en  (ev_pre | (ev_col & cur_ap)),
    .wr_idx  (cur_idx),
    .set_row (cur_row),
    .rd_idx  (cur_idx),
    .rd_open (lk_open),
    .rd_row  (lk_row)
  );

  brt_gap_timer #(.GAP(T_RP)) u_rp_timer (
    .clk(clk), .rst_n(rst_n), .load(ev_pre), .done(rp_done)
  );

  brt_gap_timer #(.GAP(T_RCD)) u_rcd_timer (
    .clk(clk), .rst_n(rst_n), .load(ev_act), .done(rcd_done)
  );

  assign lk_hit   = (lk_row == cur_row);
  assign ev_take  = in_idle && req_valid;
  assign ev_pre   = ev_take && lk_open && !lk_hit;
  assign ev_act   = (ev_take && !lk_open) || (state_q == ST_RP && rp_done);
  assign ev_col   = (ev_take && lk_open && lk_hit) || (state_q == ST_RCD && rcd_done);
  assign req_ready = in_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      q_write   <= 1'b0;
      q_ap      <= 1'b0;
      q_bg      <= '0;
      q_ba      <= '0;
      q_row     <= '0;
      q_col     <= '0;
      cmd_cs_n  <= 1'b1;
      cmd_act_n <= 1'b1;
      cmd_code  <= CODE_NOP;
      cmd_bg    <= '0;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
    end else begin
      cmd_cs_n  <= 1'b1;
      cmd_act_n <= 1'b1;
      cmd_code  <= CODE_NOP;
      cmd_bg    <= '0;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;

      if (ev_take) begin
        q_write <= req_write;
        q_ap    <= req_autopre;
        q_bg    <= req_bg;
        q_ba    <= req_ba;
        q_row   <= req_row;
        q_col   <= req_col;
      end

      if (ev_pre) begin
        cmd_cs_n <= 1'b0;
        cmd_code <= CODE_PRE;
        cmd_bg   <= cur_bg;
        cmd_ba   <= cur_ba;
      end
      if (ev_act) begin
        cmd_cs_n  <= 1'b0;
        cmd_act_n <= 1'b0;
        cmd_code  <= CODE_ACT;
        cmd_bg    <= cur_bg;
        cmd_ba    <= cur_ba;
        cmd_addr  <= widen_row(cur_row);
      end
      if (ev_col) begin
        cmd_cs_n <= 1'b0;
        cmd_code <= cur_write ? CODE_WR : CODE_RD;
        cmd_bg   <= cur_bg;
        cmd_ba   <= cur_ba;
        cmd_addr <= widen_col(cur_col);
        cmd_ap   <= cur_ap;
      end

      case (state_q)
        ST_IDLE: begin
          if (ev_pre) state_q <= ST_RP;
          else if (ev_act) state_q <= ST_RCD;
        end
        ST_RP:   if (rp_done)  state_q <= ST_RCD;
        ST_RCD:  if (rcd_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brt_checker.sv
module brt_checker
  import brt_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int T_RP  = 2,
  parameter int T_RCD = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            cmd_cs_n,
  input logic            cmd_act_n,
  input logic [2:0]      cmd_code,
  input logic [BG_W-1:0] cmd_bg,
  input logic [BA_W-1:0] cmd_ba,
  input logic            cmd_ap,
  input logic            ev_pre,
  input logic            ev_act,
  input logic            ev_col
);
  localparam int IDX_W = BG_W + BA_W;
  localparam int NB = 1 << IDX_W;
  localparam int unsigned SAT = 32'd1 << 20;

  logic is_act, is_pre, is_col;
  logic [IDX_W-1:0] c_idx;
  logic [NB-1:0] sh_open;
  int unsigned since_act, since_pre;

  assign is_act = !cmd_cs_n && !cmd_act_n && cmd_code == CODE_ACT;
  assign is_pre = !cmd_cs_n && cmd_act_n && cmd_code == CODE_PRE;
  assign is_col = !cmd_cs_n && cmd_act_n && (cmd_code == CODE_RD || cmd_code == CODE_WR);
  assign c_idx  = {cmd_bg, cmd_ba};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_open   <= '0;
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      if (is_act) sh_open[c_idx] <= 1'b1;
      else if (is_pre || (is_col && cmd_ap)) sh_open[c_idx] <= 1'b0;
      if (is_act) since_act <= 1;
      else if (since_act < SAT) since_act <= since_act + 1;
      if (is_pre) since_pre <= 1;
      else if (since_pre < SAT) since_pre <= since_pre + 1;
    end
  end

  assert_idle_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs_n |-> (cmd_act_n && cmd_code == CODE_NOP && !cmd_ap));
  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cs_n |-> (is_act || is_pre || is_col));
  assert_act_to_col_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act >= T_RCD);
  assert_pre_to_act_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre >= T_RP);
  assert_act_bank_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !sh_open[c_idx]);
  assert_pre_bank_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sh_open[c_idx]);
  assert_col_bank_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> sh_open[c_idx]);
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_pre) |-> !req_ready);
  assert_ap_on_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ap |-> is_col);
  assert_act_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> is_act);
  assert_pre_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |=> is_pre);
  assert_col_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col |=> is_col);
endmodule

bind bank_row_tracker brt_checker #(
  .BG_W(BG_W), .BA_W(BA_W), .T_RP(T_RP), .T_RCD(T_RCD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .cmd_cs_n(cmd_cs_n), .cmd_act_n(cmd_act_n), .cmd_code(cmd_code),
  .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_ap(cmd_ap),
  .ev_pre(ev_pre), .ev_act(ev_act), .ev_col(ev_col)
);

// File: tb/tb_bank_row_tracker.sv
`timescale 1ns/1ps
module tb_bank_row_tracker;
  localparam int BG_W = 2, BA_W = 2, ROW_W = 6, COL_W = 10, T_RP = 2, T_RCD = 3;
  localparam int ADDR_W = 10;
  localparam int NB = 16;
  localparam int CW = 1 + 1 + 3 + BG_W + BA_W + ADDR_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [BG_W-1:0] req_bg = '0;
  logic [BA_W-1:0] req_ba = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_cs_n, cmd_act_n, cmd_ap;
  logic [2:0] cmd_code;
  logic [BG_W-1:0] cmd_bg;
  logic [BA_W-1:0] cmd_ba;
  logic [ADDR_W-1:0] cmd_addr;

  bank_row_tracker #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
                     .T_RP(T_RP), .T_RCD(T_RCD)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic m_open [NB];
  logic [ROW_W-1:0] m_row [NB];

  function automatic logic [CW-1:0] nop_w();
    return {1'b1, 1'b1, 3'b111, {BG_W{1'b0}}, {BA_W{1'b0}}, {ADDR_W{1'b0}}, 1'b0};
  endfunction
  function automatic logic [CW-1:0] act_w(logic [1:0] g, logic [1:0] a, logic [ROW_W-1:0] r);
    return {1'b0, 1'b0, 3'b000, g, a, ADDR_W'(r), 1'b0};
  endfunction
  function automatic logic [CW-1:0] pre_w(logic [1:0] g, logic [1:0] a);
    return {1'b0, 1'b1, 3'b010, g, a, {ADDR_W{1'b0}}, 1'b0};
  endfunction
  function automatic logic [CW-1:0] col_w(logic w, logic p, logic [1:0] g, logic [1:0] a, logic [COL_W-1:0] c);
    return {1'b0, 1'b1, (w ? 3'b100 : 3'b101), g, a, ADDR_W'(c), p};
  endfunction

  function automatic logic [CW-1:0] actual();
    return {cmd_cs_n, cmd_act_n, cmd_code, cmd_bg, cmd_ba, cmd_addr, cmd_ap};
  endfunction

  task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected command at offset d after the accepting edge
  task automatic expect_seq(input logic wr, input logic ap, input logic [1:0] g, input logic [1:0] a,
                            input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                            output int last, output string tag);
    int idx = int'({g, a});
    if (m_open[idx] && m_row[idx] == r) begin last = 0; tag = "R3"; end
    else if (m_open[idx]) begin last = T_RP + T_RCD; tag = "R4"; end
    else begin last = T_RCD; tag = "R2"; end
  endtask

  function automatic logic [CW-1:0] exp_at(input int d, input int last, input string tag,
      input logic wr, input logic ap, input logic [1:0] g, input logic [1:0] a,
      input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    if (d == last) return col_w(wr, ap, g, a, c);
    if (tag == "R4" && d == 0) return pre_w(g, a);
    if (tag == "R4" && d == T_RP) return act_w(g, a, r);
    if (tag == "R2" && d == 0) return act_w(g, a, r);
    return nop_w();
  endfunction

  task automatic do_req(input logic wr, input logic ap, input logic [1:0] g, input logic [1:0] a,
                        input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    int last;
    string tag;
    chk({{(CW-1){1'b0}}, req_ready}, {{(CW-1){1'b0}}, 1'b1}, "R7 ready before request");
    expect_seq(wr, ap, g, a, r, c, last, tag);
    req_valid = 1'b1; req_write = wr; req_autopre = ap;
    req_bg = g; req_ba = a; req_row = r; req_col = c;
    @(negedge clk);
    req_valid = 1'b0;
    for (int d = 0; d <= last; d++) begin
      if (d > 0) @(negedge clk);
      chk(actual(), exp_at(d, last, tag, wr, ap, g, a, r, c), ap ? {tag, " R5 R6"} : {tag, " R6"});
      chk({{(CW-1){1'b0}}, req_ready}, {{(CW-1){1'b0}}, (d == last)}, "R7 ready during sequence");
    end
    m_open[int'({g, a})] = !ap;
    m_row[int'({g, a})]  = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ROW_W-1:0] r1, r2;
    logic [1:0] g, a;
    for (int i = 0; i < NB; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
    repeat (3) @(negedge clk);
    chk(actual(), nop_w(), "R1 idle command in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(actual(), nop_w(), "R1 idle command after reset");
    chk({{(CW-1){1'b0}}, req_ready}, {{(CW-1){1'b0}}, 1'b1}, "R1 ready after reset");

    // R2 / R8: open every bank
    for (int b = 0; b < NB; b++) begin
      {g, a} = 4'(b); r1 = ROW_W'(b * 5 + 1);
      do_req(1'b0, 1'b0, g, a, r1, COL_W'(b * 37 + 1));
    end
    // R3 / R8: all banks still hold their rows
    for (int b = 0; b < NB; b++) begin
      {g, a} = 4'(b); r1 = ROW_W'(b * 5 + 1);
      do_req(b[0], 1'b0, g, a, r1, COL_W'(1023 - b));
    end
    for (int b = 0; b < NB; b++) begin
      {g, a} = 4'(b); r1 = ROW_W'(b * 5 + 1); r2 = ROW_W'(b * 7 + 40);
      do_req(1'b1, 1'b0, g, a, r2, COL_W'(b * 11));      // R4 conflict
      do_req(1'b1, 1'b1, g, a, r2, COL_W'(b * 11 + 3));  // R5 hit with auto-precharge
      do_req(1'b0, 1'b0, g, a, r2, COL_W'(b + 512));     // R5 closed: activate, no precharge
      do_req(1'b0, 1'b0, g, a, r1, COL_W'(b + 256));     // R4 conflict back
    end

    // R7: second request held during the stall of a conflict
    begin
      logic [ROW_W-1:0] rb0 = ROW_W'(1), rb0n = ROW_W'(63), rb1 = ROW_W'(6);
      req_valid = 1'b1; req_write = 1'b0; req_autopre = 1'b0;
      req_bg = 2'd0; req_ba = 2'd0; req_row = rb0n; req_col = COL_W'(77);
      @(negedge clk);
      req_bg = 2'd0; req_ba = 2'd1; req_row = rb1; req_col = COL_W'(99); req_write = 1'b1;
      for (int d = 0; d <= T_RP + T_RCD + 1; d++) begin
        logic [CW-1:0] e;
        if (d > 0) @(negedge clk);
        if (d == 0) e = pre_w(2'd0, 2'd0);
        else if (d == T_RP) e = act_w(2'd0, 2'd0, rb0n);
        else if (d == T_RP + T_RCD) e = col_w(1'b0, 1'b0, 2'd0, 2'd0, COL_W'(77));
        else if (d == T_RP + T_RCD + 1) e = col_w(1'b1, 1'b0, 2'd0, 2'd1, COL_W'(99));
        else e = nop_w();
        chk(actual(), e, "R7 held request waits for ready");
        chk({{(CW-1){1'b0}}, req_ready}, {{(CW-1){1'b0}}, (d >= T_RP + T_RCD)}, "R7 ready while held");
        if (d == T_RP + T_RCD + 1) req_valid = 1'b0;
      end
      if (rb0 == m_row[0]) m_row[0] = rb0n;
      @(negedge clk);
      chk(actual(), nop_w(), "R7 held request issued once");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule